// File: doc/BRIEF.md
# Four-Bit Accumulator Controller Datapath

This block is the execute half of a tiny 4-bit controller. An instruction word arrives from outside every clock, with no fetch stage. The block decodes it and applies it to four 4-bit working registers and a 16-word by 4-bit scratch memory. Register 0 is the accumulator. It is the fixed destination operand of every ALU operation, and the only register an ALU result is written to. The second operand comes from whichever register a one-hot field in the instruction names. A separate group of load opcodes copies a memory word straight into any one of the four registers, without passing through the ALU.

The memory is filled from outside through its own write port: an address, write data and a write enable. An instruction addresses the memory only for loads, through its own address field. The block drives the accumulator value and a carry flag.

The instruction port uses a valid/ready pair. Ready is low only while reset is held. Outside reset it is high, so the block applies no back-pressure, and every instruction presented with valid high executes in that cycle. A cycle with valid low changes nothing.

Top module: `mcu4_core`

## Requirements
- R1: Instruction layout is `{sel[11:8], addr[7:4], op[3:0]}`. An instruction executes on a rising edge only when `instr_valid` is high. With `instr_valid` low, `data_out` and `carry_out` hold. `instr_ready` is low while `rst` is high and high otherwise.
- R2: The select field picks the second ALU operand: 0001 gives A (the accumulator), 0010 gives B, 0100 gives C and 1000 gives D.
- R3: Op 0000 sets A to A+S, with carry set to the carry out of bit 3. Op 0001 sets A to A−S, with carry set to the borrow (1 when A<S). Op 0010 sets carry to that same borrow and leaves A unchanged.
- R4: Op 0011 shifts A left and op 0100 shifts A right, both filling with 0. Op 0101 rotates A left and op 0110 rotates A right. In all four cases carry takes the bit moved out of A.
- R5: Op 0111 sets A to A AND S, op 1000 sets A to A OR S, and op 1001 sets A to NOT A. All three leave carry unchanged.
- R6: Ops 1010, 1011, 1100 and 1101 load the memory word at `addr[7:4]` into A, B, C and D respectively. Carry is unchanged.
- R7: With `mem_we` high, `mem_wdata` is written to the word at `mem_addr` on the rising edge. A load in the same cycle from the same word gets the value held before that write.
- R8: Ops 1110 and 1111, and any select value that is not one-hot (0000 included), write no register and leave carry unchanged.
- R9: Synchronous reset clears A, B, C, D and carry. Memory contents survive reset.
- R10: `data_out` always shows the current accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present |
| instr_ready | output | 1 | Instruction accepted; low only during reset |
| instr | input | 12 | Instruction word {sel, addr, op} |
| mem_we | input | 1 | Memory write enable |
| mem_addr | input | 4 | Memory write address |
| mem_wdata | input | 4 | Memory write data |
| data_out | output | 4 | Accumulator contents |
| carry_out | output | 1 | Carry/borrow flag |

## Verification
The bench builds the block with its defaults: 4-bit words, a 4-bit memory address and four registers. At these values the carry and borrow wrap after only a few additions or subtractions, and each shift or rotate moves a bit out after at most four steps. The select field is exactly four bits, so every one-hot value and several values that are not one-hot can be driven directly. A hand-computed instruction sequence runs through every opcode, including the two reserved ones. Directed cases then cover a reset midway through a program and a load that shares an edge with a memory write to the same word.

// File: rtl/mcu4_pkg.sv
package mcu4_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_CMP  = 4'h2,
    OP_SHL  = 4'h3,
    OP_SHR  = 4'h4,
    OP_ROL  = 4'h5,
    OP_ROR  = 4'h6,
    OP_AND  = 4'h7,
    OP_OR   = 4'h8,
    OP_NOT  = 4'h9,
    OP_LDA  = 4'hA,
    OP_LDB  = 4'hB,
    OP_LDC  = 4'hC,
    OP_LDD  = 4'hD,
    OP_RSV0 = 4'hE,
    OP_RSV1 = 4'hF
  } op_e;
endpackage

// File: rtl/mcu4_alu.sv
module mcu4_alu
  import mcu4_pkg::*;
#(
  parameter int DW = 4
) (
  input  op_e           op,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] src,
  input  logic          carry_in,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          wr_acc
);
  logic [DW:0] sum;
  logic [DW:0] diff;

  assign sum  = {1'b0, dst} + {1'b0, src};
  assign diff = {1'b0, dst} - {1'b0, src};

  always_comb begin
    res    = dst;
    c_out  = carry_in;
    wr_acc = 1'b0;
    case (op)
      OP_ADD: begin res = sum[DW-1:0];  c_out = sum[DW];  wr_acc = 1'b1; end
      OP_SUB: begin res = diff[DW-1:0]; c_out = diff[DW]; wr_acc = 1'b1; end
      OP_CMP: begin c_out = diff[DW]; end
      OP_SHL: begin res = {dst[DW-2:0], 1'b0};      c_out = dst[DW-1]; wr_acc = 1'b1; end
      OP_SHR: begin res = {1'b0, dst[DW-1:1]};      c_out = dst[0];    wr_acc = 1'b1; end
      OP_ROL: begin res = {dst[DW-2:0], dst[DW-1]}; c_out = dst[DW-1]; wr_acc = 1'b1; end
      OP_ROR: begin res = {dst[0], dst[DW-1:1]};    c_out = dst[0];    wr_acc = 1'b1; end
      OP_AND: begin res = dst & src; wr_acc = 1'b1; end
      OP_OR:  begin res = dst | src; wr_acc = 1'b1; end
      OP_NOT: begin res = ~dst;      wr_acc = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcu4_decode.sv
module mcu4_decode
  import mcu4_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic            valid,
  input  op_e             op,
  input  logic [NREG-1:0] sel,
  output logic            alu_go,
  output logic [NREG-1:0] ld_en
);
  localparam logic [OPW-1:0] LD_BASE  = OP_LDA;
  localparam logic [OPW-1:0] ALU_LAST = OP_NOT;

  logic           sel_onehot;
  logic           exec;
  logic [OPW-1:0] opv;

  assign opv        = op;
  assign sel_onehot = (sel != '0) && ((sel & (sel - NREG'(1))) == '0);
  assign exec       = valid && sel_onehot;
  assign alu_go     = exec && (opv <= ALU_LAST);

  for (genvar i = 0; i < NREG; i++) begin : g_ld
    assign ld_en[i] = exec && (opv == LD_BASE + OPW'(i));
  end
endmodule

// File: rtl/mcu4_regs.sv
module mcu4_regs #(
  parameter int DW   = 4,
  parameter int NREG = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREG-1:0]          ld_en,
  input  logic [DW-1:0]            ld_data,
  input  logic                     acc_we,
  input  logic [DW-1:0]            acc_data,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    if (i == 0) begin : g_acc
      always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (ld_en[i]) q <= ld_data;
        else if (acc_we)   q <= acc_data;
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (ld_en[i]) q <= ld_data;
      end
    end
    assign regs[i] = q;
  end
endmodule

// File: rtl/mcu4_srcmux.sv
module mcu4_srcmux #(
  parameter int DW   = 4,
  parameter int NREG = 4
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [NREG-1:0]         sel,
  output logic [DW-1:0]           src
);
  logic [NREG-1:0][DW-1:0] gated;

  for (genvar i = 0; i < NREG; i++) begin : g_gate
    assign gated[i] = regs[i] & {DW{sel[i]}};
  end

  always_comb begin
    src = '0;
    for (int i = 0; i < NREG; i++) src = src | gated[i];
  end
endmodule

// File: rtl/mcu4_ram.sv
module mcu4_ram #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mcu4_core.sv
module mcu4_core
  import mcu4_pkg::*;
#(
  parameter int DW   = 4,
  parameter int AW   = 4,
  parameter int NREG = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     instr_valid,
  output logic                     instr_ready,
  input  logic [NREG+AW+OPW-1:0]   instr,
  input  logic                     mem_we,
  input  logic [AW-1:0]            mem_addr,
  input  logic [DW-1:0]            mem_wdata,
  output logic [DW-1:0]            data_out,
  output logic                     carry_out
);
  localparam int IW      = NREG + AW + OPW;
  localparam int AD_LSB  = OPW;
  localparam int SEL_LSB = OPW + AW;

  op_e                      op;
  logic [AW-1:0]            ld_addr;
  logic [NREG-1:0]          sel;
  logic [NREG-1:0][DW-1:0]  regs;
  logic [DW-1:0]            src;
  logic [DW-1:0]            rdata;
  logic [DW-1:0]            alu_res;
  logic                     alu_c;
  logic                     alu_wr;
  logic                     alu_go;
  logic [NREG-1:0]          ld_en;
  logic                     carry_q;

  assign op      = op_e'(instr[OPW-1:0]);
  assign ld_addr = instr[AD_LSB +: AW];
  assign sel     = instr[SEL_LSB +: NREG];

  assign instr_ready = !rst;

  mcu4_decode #(.NREG(NREG)) u_dec (
    .valid  (instr_valid),
    .op     (op),
    .sel    (sel),
    .alu_go (alu_go),
    .ld_en  (ld_en)
  );

  mcu4_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (ld_addr),
    .rdata (rdata)
  );

  mcu4_srcmux #(.DW(DW), .NREG(NREG)) u_mux (
    .regs (regs),
    .sel  (sel),
    .src  (src)
  );

  mcu4_alu #(.DW(DW)) u_alu (
    .op       (op),
    .dst      (regs[0]),
    .src      (src),
    .carry_in (carry_q),
    .res      (alu_res),
    .c_out    (alu_c),
    .wr_acc   (alu_wr)
  );

  mcu4_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_data  (rdata),
    .acc_we   (alu_go && alu_wr),
    .acc_data (alu_res),
    .regs     (regs)
  );

  always_ff @(posedge clk) begin
    if (rst)         carry_q <= 1'b0;
    else if (alu_go) carry_q <= alu_c;
  end

  assign data_out  = regs[0];
  assign carry_out = carry_q;

  if (IW != SEL_LSB + NREG) begin : g_bad_width
    $error("instruction width mismatch");
  end
endmodule

// File: rtl/mcu4_core_chk.sv
module mcu4_core_chk #(
  parameter int DW   = 4,
  parameter int AW   = 4,
  parameter int NREG = 4,
  parameter int IW   = NREG + AW + 4
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_valid,
  input logic [IW-1:0] instr,
  input logic [DW-1:0] data_out,
  input logic          carry_out
);
  logic [3:0]      opc;
  logic [NREG-1:0] sel;
  logic            one_hot;
  logic            rst_q;

  assign opc     = instr[3:0];
  assign sel     = instr[IW-1 -: NREG];
  assign one_hot = ($countones(sel) == 1);

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b0)
      AST_RESET_CLEARS: assert (data_out == '0 && carry_out == 1'b0); // R9
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(data_out) && $stable(carry_out))); // R1

  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (opc >= 4'hE || !one_hot)) |=> ($stable(data_out) && $stable(carry_out))); // R8

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && one_hot && opc == 4'h2) |=> $stable(data_out)); // R3

  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc >= 4'h7 && opc <= 4'hD) |=> $stable(carry_out)); // R5

  AST_LOAD_OTHER_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc >= 4'hB && opc <= 4'hD) |=> $stable(data_out)); // R6

  AST_SELF_ADD_DOUBLES: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc == 4'h0 && sel == NREG'(1)) |=> (data_out == DW'($past(data_out) << 1))); // R2
endmodule

bind mcu4_core mcu4_core_chk #(.DW(DW), .AW(AW), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .data_out    (data_out),
  .carry_out   (carry_out)
);

// File: tb/mcu4_core_tb_top.sv
`timescale 1ns/1ps
module mcu4_core_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic        instr_ready;
  logic [11:0] instr;
  logic        mem_we;
  logic [3:0]  mem_addr;
  logic [3:0]  mem_wdata;
  logic [3:0]  data_out;
  logic        carry_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mcu4_core dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .data_out(data_out), .carry_out(carry_out)
  );

  // {valid, sel, addr, op, expected A, expected carry}
  localparam int NV = 31;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 4'h1, 4'h0, 4'hA, 4'h5, 1'b0},  // R6 load A
    {1'b1, 4'h1, 4'h1, 4'hB, 4'h5, 1'b0},  // R6 load B
    {1'b1, 4'h1, 4'h2, 4'hC, 4'h5, 1'b0},  // R6 load C
    {1'b1, 4'h1, 4'h3, 4'hD, 4'h5, 1'b0},  // R6 load D
    {1'b1, 4'h2, 4'h0, 4'h0, 4'hE, 1'b0},  // R3 add B
    {1'b1, 4'h8, 4'h0, 4'h0, 4'hD, 1'b1},  // R3 add D carry
    {1'b1, 4'h4, 4'h0, 4'h1, 4'hA, 1'b0},  // R3 sub C
    {1'b1, 4'h8, 4'h0, 4'h2, 4'hA, 1'b1},  // R3 cmp D borrow
    {1'b1, 4'h2, 4'h0, 4'h1, 4'h1, 1'b0},  // R3 sub B
    {1'b1, 4'h8, 4'h0, 4'h1, 4'h2, 1'b1},  // R3 sub borrow
    {1'b1, 4'h1, 4'h0, 4'h3, 4'h4, 1'b0},  // R4 shl
    {1'b1, 4'h1, 4'h3, 4'hA, 4'hF, 1'b0},  // R6 load A
    {1'b1, 4'h1, 4'h0, 4'h3, 4'hE, 1'b1},  // R4 shl out 1
    {1'b1, 4'h1, 4'h0, 4'h4, 4'h7, 1'b0},  // R4 shr
    {1'b1, 4'h1, 4'h0, 4'h6, 4'hB, 1'b1},  // R4 ror
    {1'b1, 4'h1, 4'h0, 4'h5, 4'h7, 1'b1},  // R4 rol
    {1'b1, 4'h4, 4'h0, 4'h7, 4'h3, 1'b1},  // R5 and C
    {1'b1, 4'h2, 4'h0, 4'h8, 4'hB, 1'b1},  // R5 or B
    {1'b1, 4'h1, 4'h0, 4'h9, 4'h4, 1'b1},  // R5 not
    {1'b1, 4'h1, 4'h0, 4'hE, 4'h4, 1'b1},  // R8 reserved op
    {1'b1, 4'h3, 4'h0, 4'h0, 4'h4, 1'b1},  // R8 sel 0011
    {1'b1, 4'h0, 4'h0, 4'h0, 4'h4, 1'b1},  // R8 sel 0000
    {1'b1, 4'h1, 4'h0, 4'h0, 4'h8, 1'b0},  // R2 A as source
    {1'b1, 4'h4, 4'h0, 4'h2, 4'h8, 1'b0},  // R3 cmp no borrow
    {1'b0, 4'h2, 4'h0, 4'h0, 4'h8, 1'b0},  // R1 valid low
    {1'b1, 4'h1, 4'h4, 4'hA, 4'hA, 1'b0},  // R6 load A
    {1'b1, 4'h1, 4'h0, 4'h5, 4'h5, 1'b1},  // R4 rol
    {1'b1, 4'h1, 4'h5, 4'hB, 4'h5, 1'b1},  // R6 load B keeps A, carry
    {1'b1, 4'h2, 4'h0, 4'h0, 4'h6, 1'b0},  // R2 new B used
    {1'b1, 4'h1, 4'h0, 4'hF, 4'h6, 1'b0},  // R8 reserved op
    {1'b1, 4'h6, 4'h3, 4'hA, 4'h6, 1'b0}   // R8 load with bad sel
  };

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] ins, input logic we,
                      input logic [3:0] wa, input logic [3:0] wd);
    @(negedge clk);
    instr_valid = v; instr = ins; mem_we = we; mem_addr = wa; mem_wdata = wd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = '0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready low in reset", {3'b0, instr_ready}, 4'h0);
    chk("R9 reset A", data_out, 4'h0);
    chk("R9 reset carry", {3'b0, carry_out}, 4'h0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 ready high", {3'b0, instr_ready}, 4'h1);

    // R7 preload memory
    step(1'b0, 12'h000, 1'b1, 4'h0, 4'h5);
    step(1'b0, 12'h000, 1'b1, 4'h1, 4'h9);
    step(1'b0, 12'h000, 1'b1, 4'h2, 4'h3);
    step(1'b0, 12'h000, 1'b1, 4'h3, 4'hF);
    step(1'b0, 12'h000, 1'b1, 4'h4, 4'hA);
    step(1'b0, 12'h000, 1'b1, 4'h5, 4'h1);
    step(1'b0, 12'h000, 1'b1, 4'h6, 4'h2);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16:5], 1'b0, 4'h0, 4'h0);
      chk($sformatf("R10 vec%0d data_out", i), data_out, VEC[i][4:1]);
      chk($sformatf("R3 vec%0d carry", i), {3'b0, carry_out}, {3'b0, VEC[i][0]});
    end

    // R9 reset mid-program: registers cleared, memory kept
    @(negedge clk); rst = 1'b1; instr_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 ready low in reset", {3'b0, instr_ready}, 4'h0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R9 A cleared", data_out, 4'h0);
    chk("R9 carry cleared", {3'b0, carry_out}, 4'h0);
    step(1'b1, 12'h10A, 1'b0, 4'h0, 4'h0);
    chk("R9 memory kept", data_out, 4'h5);
    step(1'b1, 12'h200, 1'b0, 4'h0, 4'h0);
    chk("R9 B cleared", data_out, 4'h5);
    step(1'b1, 12'h400, 1'b0, 4'h0, 4'h0);
    chk("R9 C cleared", data_out, 4'h5);
    step(1'b1, 12'h800, 1'b0, 4'h0, 4'h0);
    chk("R9 D cleared", data_out, 4'h5);
    chk("R9 carry after adds", {3'b0, carry_out}, 4'h0);

    // R7 write and load on the same edge to the same word
    step(1'b1, 12'h16A, 1'b1, 4'h6, 4'h7);
    chk("R7 same-edge load old", data_out, 4'h2);
    step(1'b1, 12'h16A, 1'b0, 4'h0, 4'h0);
    chk("R7 new word visible", data_out, 4'h7);
    // R7 write with valid low does not touch A
    step(1'b0, 12'h16A, 1'b1, 4'h6, 4'hC);
    chk("R7 write only", data_out, 4'h7);
    step(1'b1, 12'h16A, 1'b0, 4'h0, 4'h0);
    chk("R7 written word loaded", data_out, 4'hC);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule